// File: doc/BRIEF.md
# Board Interrupt Expander Register Bank

This block gathers five board-level interrupt sources (an Ethernet controller, two external UARTs and two push buttons) into one active-low, level-sensitive interrupt line for a host processor. Each raw source is brought into the clock domain through a two-flop synchroniser. A rising edge on the synchronised signal latches a pending bit. Software reads the pending bits, blocks unwanted sources through a mask register, and clears bits by writing a one and then a zero to a separate clear register.

The host reaches the block over a simple synchronous 16-bit register bus made of a byte address, a write strobe, write data and combinational read data. Besides the interrupt registers, the bank holds three constant signature words that let software confirm the board is fitted. It also holds a version word and a board ID word, both set by parameters. Two writable output registers drive the LEDs and the module reset lines, and one read-only register shows the synchronised button inputs.

Top module: `irq_expander_regs`

## Requirements
- R1: After reset the mask register (offset 0x38) reads 0x001F, the status register (0x10), the LED register (0x00), the module reset register (0x60) and the clear register (0x20) read 0x0000, and irq_n is high.
- R2: Offset 0x40 reads 0xAAAA, offset 0x48 reads 0x5555 and offset 0x58 reads 0xCAFE. Writes to these offsets do not change them.
- R3: Offset 0x50 reads the VERSION parameter and offset 0x68 reads the BOARD_ID parameter.
- R4: A rising edge on src_raw[i] sets status bit i at 0x10 (bit 0 Ethernet, 1 UART A, 2 UART B, 3 button A, 4 button B) within four clock edges. The bit stays set after the source falls. A source held high does not set the bit again after it has been cleared. Status bits 15..5 read 0.
- R5: Writing a 1 to bit i of the clear register (0x20) clears status bit i. While that clear bit stays 1, edges on source i leave the status bit at 0. After a 0 is written back, new edges set the bit again. The clear register reads back its held value in bits 4..0.
- R6: A 1 in mask bit i (0x38, bits 4..0) keeps status bit i off the output. irq_n is low exactly when some status bit is set and its mask bit is 0.
- R7: The start-up sequence (mask 0, clear 0xFFFF, clear 0, mask 0x1F) leaves all status bits clear, the mask at 0x001F and irq_n high, even when sources were pending before it.
- R8: The LED register (0x00) and the module reset register (0x60) hold 16-bit values that read back and drive led_out and modrst_out.
- R9: The button register (0x08) shows btn_raw after two clock edges of synchronisation. Its bits above BTN_W read 0.
- R10: Reads of unmapped offsets return 0x0000. Writes to read-only or unmapped offsets change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| src_raw | input | NSRC | Raw interrupt sources, asynchronous |
| btn_raw | input | BTN_W | Raw button levels, asynchronous |
| led_out | output | 16 | LED register contents |
| modrst_out | output | 16 | Module reset register contents |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
A corrupt pending bit shows up at two places. It appears in the status read at the next access, and it changes irq_n in the same cycle once that bit is unmasked. A stuck or missing clear shows up as a status bit that stays set, or fails to set again, after the one-then-zero write pair. A broken edge detector shows up either as a level that sets the bit again right after a clear, or as a bit that never sets within four clock edges of a pulse. Decode faults show up at once as a wrong constant word, a changed LED or module reset output after a stray write, or non-zero data from an unmapped offset.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  localparam int BUS_W = 16;

  localparam logic [7:0] OFF_LED    = 8'h00;
  localparam logic [7:0] OFF_BTN    = 8'h08;
  localparam logic [7:0] OFF_STAT   = 8'h10;
  localparam logic [7:0] OFF_CLR    = 8'h20;
  localparam logic [7:0] OFF_MASK   = 8'h38;
  localparam logic [7:0] OFF_SIG_A  = 8'h40;
  localparam logic [7:0] OFF_SIG_B  = 8'h48;
  localparam logic [7:0] OFF_VER    = 8'h50;
  localparam logic [7:0] OFF_SIG_C  = 8'h58;
  localparam logic [7:0] OFF_MODRST = 8'h60;
  localparam logic [7:0] OFF_BID    = 8'h68;

  localparam logic [BUS_W-1:0] SIG_A_VAL = 16'hAAAA;
  localparam logic [BUS_W-1:0] SIG_B_VAL = 16'h5555;
  localparam logic [BUS_W-1:0] SIG_C_VAL = 16'hCAFE;

  // Active-high request: any pending source whose block bit is clear
  function automatic logic any_live(input logic [15:0] pend, input logic [15:0] blk);
    return |(pend & ~blk);
  endfunction

  // Zero-extend a narrow field onto the bus
  function automatic logic [BUS_W-1:0] widen(input logic [BUS_W-1:0] v, input int w);
    logic [BUS_W-1:0] m;
    m = (w >= BUS_W) ? {BUS_W{1'b1}} : ((16'd1 << w) - 16'd1);
    return v & m;
  endfunction
endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_sync <= '0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/irqx_edge.sv
module irqx_edge #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_chk
      // R4: an edge marker lasts a single cycle while the level is held
      assert_rise_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise[i] |=> !rise[i]);
    end
  endgenerate
endmodule

// File: rtl/irqx_status.sv
module irqx_status #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise,
  input  logic         wr_mask,
  input  logic         wr_clr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] clr_o,
  output logic         irq_n_o
);
  import irqx_pkg::*;

  logic [N-1:0] pend_q, mask_q, clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      clr_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      if (wr_clr)  clr_q  <= wdata;
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend_q[i] <= 1'b0;
        else if (clr_q[i]) pend_q[i] <= 1'b0;
        else if (rise[i])  pend_q[i] <= 1'b1;
      end

      // R4: a pending bit only appears after a detected edge
      assert_set_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[i]) |-> $past(rise[i]));
      // R5: a held clear bit keeps its pending bit at zero
      assert_clear_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q[i] |=> !pend_q[i]);
    end
  endgenerate

  assign irq_n_o = ~any_live(16'(pend_q), 16'(mask_q));
  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
  assign clr_o   = clr_q;

  // R6: blocking every source releases the line on the next cycle
  assert_full_mask_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && (&wdata)) |=> irq_n_o);
endmodule

// File: rtl/irq_expander_regs.sv
module irq_expander_regs #(
  parameter int          ADDR_W   = 8,
  parameter int          NSRC     = 5,
  parameter int          BTN_W    = 4,
  parameter logic [15:0] VERSION  = 16'h0103,
  parameter logic [15:0] BOARD_ID = 16'h0051
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_raw,
  input  logic [BTN_W-1:0]  btn_raw,
  output logic [15:0]       led_out,
  output logic [15:0]       modrst_out,
  output logic              irq_n
);
  import irqx_pkg::*;

  logic [NSRC-1:0]  src_sync, src_rise, pend, mask, clr;
  logic [BTN_W-1:0] btn_sync;
  logic [15:0]      led_q, modrst_q;
  logic             wr_led, wr_modrst, wr_mask, wr_clr;

  irqx_sync #(.W(NSRC)) u_src_sync (
    .clk(clk), .rst_n(rst_n), .d_async(src_raw), .q_sync(src_sync));

  irqx_edge #(.W(NSRC)) u_src_edge (
    .clk(clk), .rst_n(rst_n), .lvl(src_sync), .rise(src_rise));

  irqx_sync #(.W(BTN_W)) u_btn_sync (
    .clk(clk), .rst_n(rst_n), .d_async(btn_raw), .q_sync(btn_sync));

  assign wr_led    = bus_wr && (bus_addr == ADDR_W'(OFF_LED));
  assign wr_modrst = bus_wr && (bus_addr == ADDR_W'(OFF_MODRST));
  assign wr_mask   = bus_wr && (bus_addr == ADDR_W'(OFF_MASK));
  assign wr_clr    = bus_wr && (bus_addr == ADDR_W'(OFF_CLR));

  irqx_status #(.N(NSRC)) u_status (
    .clk(clk), .rst_n(rst_n), .rise(src_rise),
    .wr_mask(wr_mask), .wr_clr(wr_clr), .wdata(bus_wdata[NSRC-1:0]),
    .pend_o(pend), .mask_o(mask), .clr_o(clr), .irq_n_o(irq_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q    <= '0;
      modrst_q <= '0;
    end else begin
      if (wr_led)    led_q    <= bus_wdata;
      if (wr_modrst) modrst_q <= bus_wdata;
    end
  end

  assign led_out    = led_q;
  assign modrst_out = modrst_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_LED):    bus_rdata = led_q;
      ADDR_W'(OFF_BTN):    bus_rdata = widen(16'(btn_sync), BTN_W);
      ADDR_W'(OFF_STAT):   bus_rdata = widen(16'(pend), NSRC);
      ADDR_W'(OFF_CLR):    bus_rdata = widen(16'(clr), NSRC);
      ADDR_W'(OFF_MASK):   bus_rdata = widen(16'(mask), NSRC);
      ADDR_W'(OFF_SIG_A):  bus_rdata = SIG_A_VAL;
      ADDR_W'(OFF_SIG_B):  bus_rdata = SIG_B_VAL;
      ADDR_W'(OFF_VER):    bus_rdata = VERSION;
      ADDR_W'(OFF_SIG_C):  bus_rdata = SIG_C_VAL;
      ADDR_W'(OFF_MODRST): bus_rdata = modrst_q;
      ADDR_W'(OFF_BID):    bus_rdata = BOARD_ID;
      default:             bus_rdata = '0;
    endcase
  end

  // R10: a write elsewhere leaves the LED outputs untouched
  assert_led_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != ADDR_W'(OFF_LED)) |=> $stable(led_out));
  // R8: a write elsewhere leaves the module reset outputs untouched
  assert_modrst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != ADDR_W'(OFF_MODRST)) |=> $stable(modrst_out));
endmodule

// File: tb/irq_expander_regs_bench.sv
module irq_expander_regs_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [4:0]  src_raw = '0;
  logic [3:0]  btn_raw = '0;
  logic [15:0] led_out, modrst_out;
  logic        irq_n;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_expander_regs u_irq_expander_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_raw(src_raw),
    .btn_raw(btn_raw), .led_out(led_out), .modrst_out(modrst_out), .irq_n(irq_n));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk);
    src_raw = src_raw | m;
    cycles(4);
    src_raw = src_raw & ~m;
    cycles(4);
  endtask

  // Expected irq level, stated from the mask rule
  function automatic logic exp_irq_n(input logic [4:0] p, input logic [4:0] m);
    for (int i = 0; i < 5; i++) if (p[i] && !m[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    rd(8'h38, d); chk("R1 mask reset", d, 16'h001F);
    rd(8'h10, d); chk("R1 status reset", d, 16'h0000);
    rd(8'h00, d); chk("R1 led reset", d, 16'h0000);
    rd(8'h60, d); chk("R1 modrst reset", d, 16'h0000);
    rd(8'h20, d); chk("R1 clear reset", d, 16'h0000);
    chk("R1 irq_n reset", {15'd0, irq_n}, 16'd1);
  endtask

  task automatic t_sig();
    logic [15:0] d;
    rd(8'h40, d); chk("R2 sig 0x40", d, 16'hAAAA);
    rd(8'h48, d); chk("R2 sig 0x48", d, 16'h5555);
    rd(8'h58, d); chk("R2 sig 0x58", d, 16'hCAFE);
    wr(8'h40, 16'h1234); wr(8'h58, 16'h0000);
    rd(8'h40, d); chk("R2 sig 0x40 after write", d, 16'hAAAA);
    rd(8'h58, d); chk("R2 sig 0x58 after write", d, 16'hCAFE);
  endtask

  task automatic t_ids();
    logic [15:0] d;
    rd(8'h50, d); chk("R3 version", d, 16'h0103);
    rd(8'h68, d); chk("R3 board id", d, 16'h0051);
  endtask

  task automatic t_edge();
    logic [15:0] d;
    pulse(5'b00001);
    rd(8'h10, d); chk("R4 eth edge latched", d, 16'h0001);
    chk("R4 masked source keeps line high", {15'd0, irq_n}, 16'd1);
    @(negedge clk); src_raw[2] = 1'b1; cycles(4);
    rd(8'h10, d); chk("R4 uart B edge", d, 16'h0005);
    wr(8'h20, 16'h0004); wr(8'h20, 16'h0000); cycles(4);
    rd(8'h10, d); chk("R4 held level does not re-set", d, 16'h0001);
    src_raw[2] = 1'b0; cycles(4);
    pulse(5'b11000);
    rd(8'h10, d); chk("R4 both buttons", d, 16'h0019);
    wr(8'h20, 16'h001F); wr(8'h20, 16'h0000);
    rd(8'h10, d); chk("R4 all cleared", d, 16'h0000);
  endtask

  task automatic t_clear();
    logic [15:0] d;
    pulse(5'b00010);
    wr(8'h20, 16'h0002);
    rd(8'h20, d); chk("R5 clear readback", d, 16'h0002);
    rd(8'h10, d); chk("R5 write-one clears", d, 16'h0000);
    pulse(5'b00010);
    rd(8'h10, d); chk("R5 held clear blocks edge", d, 16'h0000);
    wr(8'h20, 16'h0000);
    pulse(5'b00010);
    rd(8'h10, d); chk("R5 edge sets after release", d, 16'h0002);
    wr(8'h20, 16'h0002); wr(8'h20, 16'h0000);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    pulse(5'b00001);
    wr(8'h38, 16'h001E);
    #1 chk("R6 unmasked pending drives low", {15'd0, irq_n}, {15'd0, exp_irq_n(5'b00001, 5'b11110)});
    wr(8'h38, 16'h001F);
    #1 chk("R6 masked again releases", {15'd0, irq_n}, {15'd0, exp_irq_n(5'b00001, 5'b11111)});
    wr(8'h38, 16'h0017);
    #1 chk("R6 other bit unmasked stays high", {15'd0, irq_n}, {15'd0, exp_irq_n(5'b00001, 5'b10111)});
    pulse(5'b01000);
    chk("R6 button A unmasked low", {15'd0, irq_n}, {15'd0, exp_irq_n(5'b01001, 5'b10111)});
    rd(8'h38, d); chk("R6 mask readback", d, 16'h0017);
  endtask

  task automatic t_init();
    logic [15:0] d;
    pulse(5'b10110);
    wr(8'h38, 16'h0000);
    wr(8'h20, 16'hFFFF);
    wr(8'h20, 16'h0000);
    wr(8'h38, 16'h001F);
    rd(8'h10, d); chk("R7 status after init", d, 16'h0000);
    rd(8'h38, d); chk("R7 mask after init", d, 16'h001F);
    chk("R7 line high after init", {15'd0, irq_n}, 16'd1);
  endtask

  task automatic t_outregs();
    logic [15:0] d;
    wr(8'h00, 16'hA5C3);
    rd(8'h00, d); chk("R8 led readback", d, 16'hA5C3);
    chk("R8 led output", led_out, 16'hA5C3);
    wr(8'h60, 16'h0F0F);
    rd(8'h60, d); chk("R8 modrst readback", d, 16'h0F0F);
    chk("R8 modrst output", modrst_out, 16'h0F0F);
  endtask

  task automatic t_buttons();
    logic [15:0] d;
    @(negedge clk); btn_raw = 4'b1010;
    cycles(3);
    rd(8'h08, d); chk("R9 button reg", d, 16'h000A);
    @(negedge clk); btn_raw = 4'b0101;
    cycles(3);
    rd(8'h08, d); chk("R9 button reg update", d, 16'h0005);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    rd(8'h18, d); chk("R10 unmapped read 0x18", d, 16'h0000);
    rd(8'hF0, d); chk("R10 unmapped read 0xF0", d, 16'h0000);
    wr(8'h18, 16'hFFFF); wr(8'h10, 16'h001F); wr(8'h08, 16'hFFFF);
    chk("R10 led untouched", led_out, 16'hA5C3);
    chk("R10 modrst untouched", modrst_out, 16'h0F0F);
    rd(8'h10, d); chk("R10 status write ignored", d, 16'h0000);
    rd(8'h38, d); chk("R10 mask untouched", d, 16'h001F);
    rd(8'h08, d); chk("R10 button write ignored", d, 16'h0005);
  endtask

  initial begin
    cycles(3);
    rst_n = 1;
    cycles(2);
    t_reset();
    t_sig();
    t_ids();
    t_edge();
    t_clear();
    t_mask();
    t_init();
    t_outregs();
    t_buttons();
    t_unmapped();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule